// File: doc/BRIEF.md
# Sequential Integer Divide and Remainder Unit

This block computes integer division for an execution pipeline. It takes a dividend and a divisor and returns either the quotient or the remainder. It handles signed and unsigned operands at two widths: a 32-bit longword and a 64-bit quadword. The divisor comes from a register operand or from a small immediate field. The quotient is computed one bit per clock by a restoring shift-subtract loop that works on operand magnitudes. A fix-up stage then applies the signs, so the quotient truncates toward zero and a non-zero remainder takes the sign of the dividend.

The unit produces two flags and does not raise a trap; the pipeline decides what to do with them. A zero divisor raises the divide-by-zero flag. A signed division of the most negative value by -1 raises the overflow flag. Both cases finish without running the loop.

Requests arrive on a valid/ready handshake. `in_ready` is high only while the unit is idle, and a request is taken on a clock edge where `in_valid` and `in_ready` are both high. An upstream stage that sees `in_ready` low must hold its request until the unit frees up. Results are not back-pressured: `out_valid` is a one-cycle pulse, and the consumer must capture `result`, `dbz` and `ovf` in that cycle.

Top module: `intdiv_unit`

## Requirements
- R1: `in_ready` is high whenever no division is in progress (including right after reset). A request is accepted on a rising edge with `in_valid` and `in_ready` both high. After accepting a request that needs the iterative loop, `in_ready` stays low until its result has been produced.
- R2: For signed operands the quotient is rounded toward zero (7 / -2 = -3, -7 / 2 = -3).
- R3: The remainder equals dividend minus divisor times the truncated quotient, so a non-zero remainder carries the dividend's sign (5 rem -3 = 2, -5 rem 3 = -2).
- R4: With `op_signed` = 0, both operands are treated as unsigned numbers of the selected width.
- R5: With `op_word` = 1, only bits 31:0 of the dividend and of the divisor are used. The 64-bit result is the 32-bit answer sign-extended from its bit 31, for unsigned forms as well.
- R6: With `use_imm` = 1, the divisor is `divisor_imm` zero-extended to 64 bits and `divisor_reg` is ignored. With `use_imm` = 0, the divisor is `divisor_reg`.
- R7: A divisor of zero (after size selection) gives `dbz` = 1, `ovf` = 0 and `result` = 0, for every combination of `op_rem`, `op_signed` and `op_word`.
- R8: A signed division of -2^31 by -1 (longword) or of -2^63 by -1 (quadword) gives `ovf` = 1 and `dbz` = 0. The result is the most negative value of the selected size, sign-extended (0xFFFFFFFF80000000 for a longword, 0x8000000000000000 for a quadword), for a quotient, and 0 for a remainder.
- R9: Unsigned division never raises `ovf`.
- R10: A division that runs the loop delivers its result exactly 32 (longword) or 64 (quadword) clock edges after the accepting edge. A divide-by-zero or overflow case delivers it at the accepting edge itself, so `out_valid` is high in the very next cycle.
- R11: `out_valid` is high for one cycle per accepted request, in the order the requests were accepted, with `result`, `dbz` and `ovf` valid in that cycle. Outside such a pulse after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| op_rem | input | 1 | 1 = return the remainder, 0 = return the quotient |
| op_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| op_word | input | 1 | 1 = 32-bit longword, 0 = 64-bit quadword |
| use_imm | input | 1 | 1 = divisor from `divisor_imm` |
| dividend | input | 64 | Dividend operand |
| divisor_reg | input | 64 | Register divisor operand |
| divisor_imm | input | 8 | Immediate divisor, zero-extended |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 64 | Quotient or remainder |
| dbz | output | 1 | Divide-by-zero flag, valid with `out_valid` |
| ovf | output | 1 | Signed overflow flag, valid with `out_valid` |

## Verification
The assertions check the following on every result pulse:
- a divide-by-zero result is zero, and the two flags are never high together;
- an unsigned request never reports overflow;
- a longword result is always a sign-extended 32-bit value;
- an overflowing quotient is the most negative value;
- the pulse comes exactly one loop length after acceptance, and `in_ready` drops once a loop starts;
- while the loop runs, the partial remainder stays below the divisor.

Only the bench scenarios can show the arithmetic itself. These are truncation toward zero, the remainder sign, the unsigned reading of large operands, the choice between immediate and register divisor, upper bits being ignored in longword mode, and results arriving in request order. Each scenario is checked against a reference model built into the bench.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

  typedef struct packed {
    logic rem;   // return remainder instead of quotient
    logic sgn;   // signed operands
    logic word;  // 32-bit longword size
  } div_op_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
  import intdiv_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 8
) (
  input  div_op_t           op_i,
  input  logic [XLEN-1:0]   dividend_i,
  input  logic [XLEN-1:0]   divisor_reg_i,
  input  logic [IMM_W-1:0]  divisor_imm_i,
  input  logic              use_imm_i,
  output logic [XLEN-1:0]   dvd_mag_o,
  output logic [XLEN-1:0]   dvs_mag_o,
  output logic              neg_q_o,
  output logic              neg_r_o,
  output logic              is_dbz_o,
  output logic              is_ovf_o,
  output logic [XLEN-1:0]   min_val_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_raw, a_ext, b_ext, a_mag, b_mag;
  logic            a_neg, b_neg;

  // Divisor source: the immediate is zero-extended to full width.
  assign b_raw = use_imm_i ? {{(XLEN-IMM_W){1'b0}}, divisor_imm_i} : divisor_reg_i;

  // Size selection: a longword is sign- or zero-extended from its low half.
  always_comb begin
    if (op_i.word) begin
      a_ext = {{HALF{op_i.sgn & dividend_i[HALF-1]}}, dividend_i[HALF-1:0]};
      b_ext = {{HALF{op_i.sgn & b_raw[HALF-1]}}, b_raw[HALF-1:0]};
    end else begin
      a_ext = dividend_i;
      b_ext = b_raw;
    end
  end

  assign a_neg = op_i.sgn & a_ext[XLEN-1];
  assign b_neg = op_i.sgn & b_ext[XLEN-1];
  assign a_mag = a_neg ? (~a_ext + 1'b1) : a_ext;
  assign b_mag = b_neg ? (~b_ext + 1'b1) : b_ext;

  // A longword magnitude is parked in the upper half so that HALF shifts
  // move all of its bits through the loop.
  assign dvd_mag_o = op_i.word ? (a_mag << HALF) : a_mag;
  assign dvs_mag_o = b_mag;

  assign neg_q_o = a_neg ^ b_neg;
  assign neg_r_o = a_neg;

  assign min_val_o = op_i.word ? {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}}
                               : {1'b1, {(XLEN-1){1'b0}}};

  assign is_dbz_o = (b_ext == '0);
  assign is_ovf_o = op_i.sgn & ~is_dbz_o & (a_ext == min_val_o) & (&b_ext);

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic [XLEN-1:0] rem_nxt_o,
  output logic [XLEN-1:0] quo_nxt_o
);
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [XLEN:0]   shifted, trial;
  logic            fits;

  // One restoring step: shift in the next dividend bit, try the subtract.
  assign shifted   = {rem_q, quo_q[XLEN-1]};
  assign trial     = shifted - {1'b0, dvs_q};
  assign fits      = ~trial[XLEN];
  assign rem_nxt_o = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
  assign quo_nxt_o = {quo_q[XLEN-2:0], fits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      rem_q <= rem_nxt_o;
      quo_q <= quo_nxt_o;
    end
  end

  AST_PARTIAL_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q < dvs_q)); // R3

endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_op_t         op_i,
  input  logic            neg_q_i,
  input  logic            neg_r_i,
  input  logic [XLEN-1:0] quo_mag_i,
  input  logic [XLEN-1:0] rem_mag_i,
  output logic [XLEN-1:0] res_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] q_signed, r_signed, pick;

  assign q_signed = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
  assign r_signed = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
  assign pick     = op_i.rem ? r_signed : q_signed;
  assign res_o    = op_i.word ? {{HALF{pick[HALF-1]}}, pick[HALF-1:0]} : pick;

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
  import intdiv_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_rem,
  input  logic             op_signed,
  input  logic             op_word,
  input  logic             use_imm,
  input  logic [XLEN-1:0]  dividend,
  input  logic [XLEN-1:0]  divisor_reg,
  input  logic [IMM_W-1:0] divisor_imm,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             dbz,
  output logic             ovf
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN);
  localparam int LW   = CW + 1;
  localparam logic [XLEN-1:0] MIN_Q = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MIN_W = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  div_state_e      state_q;
  div_op_t         op_in, op_q;
  logic [CW-1:0]   cnt_q;
  logic            negq_q, negr_q;
  logic            accept, special, load, step;
  logic [XLEN-1:0] dvd_mag, dvs_mag, min_val, rem_nxt, quo_nxt, fix_res;
  logic            neg_q, neg_r, is_dbz, is_ovf;

  assign op_in    = '{rem: op_rem, sgn: op_signed, word: op_word};
  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign special  = is_dbz | is_ovf;
  assign load     = accept & ~special;
  assign step     = (state_q == ST_RUN);

  intdiv_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
    .op_i          (op_in),
    .dividend_i    (dividend),
    .divisor_reg_i (divisor_reg),
    .divisor_imm_i (divisor_imm),
    .use_imm_i     (use_imm),
    .dvd_mag_o     (dvd_mag),
    .dvs_mag_o     (dvs_mag),
    .neg_q_o       (neg_q),
    .neg_r_o       (neg_r),
    .is_dbz_o      (is_dbz),
    .is_ovf_o      (is_ovf),
    .min_val_o     (min_val)
  );

  intdiv_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .dvd_i     (dvd_mag),
    .dvs_i     (dvs_mag),
    .rem_nxt_o (rem_nxt),
    .quo_nxt_o (quo_nxt)
  );

  intdiv_fix #(.XLEN(XLEN)) u_fix (
    .op_i      (op_q),
    .neg_q_i   (negq_q),
    .neg_r_i   (negr_q),
    .quo_mag_i (quo_nxt),
    .rem_mag_i (rem_nxt),
    .res_o     (fix_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      cnt_q     <= '0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
      dbz       <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        op_q   <= op_in;
        negq_q <= neg_q;
        negr_q <= neg_r;
        if (special) begin
          // Flag cases finish at the accepting edge without iterating.
          out_valid <= 1'b1;
          dbz       <= is_dbz;
          ovf       <= is_ovf;
          result    <= (is_dbz | op_rem) ? '0 : min_val;
        end else begin
          state_q <= ST_RUN;
          cnt_q   <= op_word ? CW'(HALF-1) : CW'(XLEN-1);
        end
      end else if (step) begin
        if (cnt_q == '0) begin
          state_q   <= ST_IDLE;
          out_valid <= 1'b1;
          dbz       <= 1'b0;
          ovf       <= 1'b0;
          result    <= fix_res;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // Cycles since the last accepted request, for the latency check only.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (step)   lat_q <= lat_q + 1'b1;
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !special) |=> !in_ready); // R1
  AST_LONG_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q.word) |-> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})); // R5
  AST_DBZ_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dbz) |-> (result == '0 && !ovf)); // R7
  AST_OVF_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf && !op_q.rem) |-> (result == (op_q.word ? MIN_W : MIN_Q))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !op_q.sgn) |-> !ovf); // R9
  AST_LOOP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dbz && !ovf) |-> (lat_q == (op_q.word ? LW'(HALF) : LW'(XLEN)))); // R10
  AST_FLAG_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result) || $past(!rst_n)); // R11

endmodule

// File: tb/intdiv_unit_bench.sv
module intdiv_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        dbz;
    logic        ovf;
    int          lat;
    int          acc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        op_rem = 1'b0, op_signed = 1'b0, op_word = 1'b0, use_imm = 1'b0;
  logic [63:0] dividend = '0, divisor_reg = '0;
  logic [7:0]  divisor_imm = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        dbz, ovf;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   issued = 0;
  int   seen = 0;
  bit   done_flag = 1'b0;
  exp_t sb[$];

  intdiv_unit u_intdiv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_rem(op_rem), .op_signed(op_signed), .op_word(op_word), .use_imm(use_imm),
    .dividend(dividend), .divisor_reg(divisor_reg), .divisor_imm(divisor_imm),
    .out_valid(out_valid), .result(result), .dbz(dbz), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic exp_t model(bit rem, bit sgn, bit word, logic [63:0] a, logic [63:0] b, string tag);
    exp_t e;
    bit bz, ov;
    int sx, sy;
    int unsigned ux, uy;
    longint lx, ly;
    longint unsigned vx, vy;
    logic [31:0] r32;
    bz = word ? (b[31:0] == 32'h0) : (b == 64'h0);
    ov = sgn && !bz && (word ? (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF)
                              : (a == 64'h8000_0000_0000_0000 && b == 64'hFFFF_FFFF_FFFF_FFFF));
    e.dbz = bz; e.ovf = ov; e.tag = tag; e.acc = 0;
    e.lat = (bz || ov) ? 0 : (word ? 32 : 64);
    if (bz) e.res = '0;
    else if (ov) e.res = rem ? 64'h0 : (word ? 64'hFFFF_FFFF_8000_0000 : 64'h8000_0000_0000_0000);
    else if (word) begin
      if (sgn) begin
        sx = a[31:0]; sy = b[31:0];
        r32 = rem ? sx % sy : sx / sy;
      end else begin
        ux = a[31:0]; uy = b[31:0];
        r32 = rem ? ux % uy : ux / uy;
      end
      e.res = {{32{r32[31]}}, r32};
    end else if (sgn) begin
      lx = a; ly = b;
      e.res = rem ? lx % ly : lx / ly;
    end else begin
      vx = a; vy = b;
      e.res = rem ? vx % vy : vx / vy;
    end
    return e;
  endfunction

  // Driver: places one request and pushes its expected outcome.
  task automatic issue(input bit rem, input bit sgn, input bit word, input bit imm_sel,
                       input logic [63:0] a, input logic [63:0] breg, input logic [7:0] bimm,
                       input string tag);
    exp_t e;
    e = model(rem, sgn, word, a, imm_sel ? {56'h0, bimm} : breg, tag);
    while (!in_ready) @(negedge clk);
    op_rem = rem; op_signed = sgn; op_word = word; use_imm = imm_sel;
    dividend = a; divisor_reg = breg; divisor_imm = bimm;
    in_valid = 1'b1;
    e.acc = cyc + 1;
    sb.push_back(e);
    issued++;
    @(negedge clk);
    in_valid = 1'b0;
    dividend = 64'hA5A5_A5A5_A5A5_A5A5;
    divisor_reg = 64'h0;
    if (e.lat != 0)
      chk(in_ready == 1'b0, {"R1 busy after accept ", tag}, {63'h0, in_ready}, 64'h0);
  endtask

  // Monitor: compares each result strobe against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (sb.size() == 0) begin
        chk(1'b0, "R11 strobe with nothing outstanding", 64'h1, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result === e.res, {"result ", e.tag}, result, e.res);
        chk(dbz === e.dbz, {"R7 dbz flag ", e.tag}, {63'h0, dbz}, {63'h0, e.dbz});
        chk(ovf === e.ovf, {"R8/R9 ovf flag ", e.tag}, {63'h0, ovf}, {63'h0, e.ovf});
        chk((cyc - e.acc) == e.lat, {"R10 latency ", e.tag}, 64'(cyc - e.acc), 64'(e.lat));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready during reset", {63'h0, in_ready}, 64'h1);
    chk(out_valid === 1'b0, "R11 no strobe during reset", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready after reset", {63'h0, in_ready}, 64'h1);

    // R2 truncation toward zero
    issue(0, 1, 0, 0, 64'd7, -64'sd2, 8'h0, "R2 7/-2");
    issue(0, 1, 0, 0, -64'sd7, 64'd2, 8'h0, "R2 -7/2");
    issue(0, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd2, 8'h0, "R2 min/2");
    issue(0, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, -64'sd4660, 8'h0, "R2 large/neg");
    // R3 remainder sign
    issue(1, 1, 0, 0, 64'd5, -64'sd3, 8'h0, "R3 5 rem -3");
    issue(1, 1, 0, 0, -64'sd5, 64'd3, 8'h0, "R3 -5 rem 3");
    issue(1, 1, 0, 0, -64'sd1000003, -64'sd7, 8'h0, "R3 neg rem neg");
    // R4 unsigned
    issue(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 8'h0, "R4 uq max/3");
    issue(1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0007, 8'h0, "R4 uq rem");
    // R5 longword
    issue(0, 1, 1, 0, 64'hDEAD_BEEF_FFFF_FFF9, 64'h1111_1111_0000_0003, 8'h0, "R5 sl -7/3");
    issue(0, 0, 1, 0, 64'h0123_4567_FFFF_FFF0, 64'hFFFF_FFFF_0000_0001, 8'h0, "R5 ul sext");
    issue(1, 0, 1, 0, 64'h0000_0000_F000_0001, 64'h0000_0000_0000_0010, 8'h0, "R5 ul rem");
    issue(1, 1, 1, 0, 64'hFFFF_FFFF_8000_0001, 64'h0000_0000_0000_0005, 8'h0, "R5 sl rem");
    // R6 immediate divisor
    issue(0, 1, 0, 1, 64'd100, 64'd3, 8'd10, "R6 imm quad");
    issue(1, 1, 1, 1, 64'h0000_0000_FFFF_FF00, 64'd0, 8'd7, "R6 imm word rem");
    issue(0, 0, 0, 1, 64'd250, 64'd1, 8'hFF, "R6 imm 255 unsigned");
    // R7 divide by zero
    issue(0, 1, 0, 0, 64'd42, 64'd0, 8'h0, "R7 sq dbz");
    issue(1, 0, 0, 0, 64'd42, 64'd0, 8'h0, "R7 uq rem dbz");
    issue(0, 0, 1, 0, 64'd9, 64'h0000_0001_0000_0000, 8'h0, "R7 ul dbz upper ignored");
    issue(1, 1, 1, 1, 64'd9, 64'd5, 8'h0, "R7 imm zero");
    // R8 signed overflow
    issue(0, 1, 0, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, "R8 sq ovf quo");
    issue(1, 1, 0, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, "R8 sq ovf rem");
    issue(0, 1, 1, 0, 64'h5555_5555_8000_0000, 64'h0000_0000_FFFF_FFFF, 8'h0, "R8 sl ovf quo");
    issue(1, 1, 1, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, "R8 sl ovf rem");
    // R9 unsigned never overflows
    issue(0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, "R9 uq min/-1");
    issue(1, 0, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 8'h0, "R9 ul min/-1");
    // R11 ordering: loop request followed directly by flag-only ones
    issue(0, 1, 1, 0, 64'd1000, 64'd7, 8'h0, "R11 loop then special");
    issue(0, 1, 1, 0, 64'd1, 64'd0, 8'h0, "R11 special a");
    issue(1, 0, 0, 0, 64'd1, 64'd0, 8'h0, "R11 special b");

    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0 && seen == issued, "R11 one strobe per request",
        64'(seen), 64'(issued));
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule